// File: doc/BRIEF.md
# Logical and Shift Execution Unit

This block executes 32-bit three-operand register instructions from two families. The bitwise family has six members: OR, OR with the second operand complemented, XOR, NAND, NOR and equivalence. The shift family has three members: shift left, logical shift right and arithmetic shift right. The first operand is the source value `in_rs`, and the second operand `in_rb` is either a bitwise partner or a shift count. The operand width is the parameter `DATA_W`, which defaults to 32.

Each accepted request produces one result a clock later on a registered output stream. When the request has its record flag set, the block also writes a three-bit sign/zero summary of the result into the top of a condition register that it holds. The other condition register bits are never written.

Operands enter on a valid/ready stream and results leave on a second one.
- Requests are accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output slot is empty or is being drained in that same cycle.
- A result that the consumer does not take (`out_valid` high, `out_ready` low) holds steady until it is taken, and no new request is accepted while it waits.

Top module: `lsx_exec_unit`

## Requirements
- R1: Operation codes 0 to 5 give, in that order, a|b, a|~b, a^b, ~(a&b), ~(a|b) and ~(a^b) over all 32 bits, where a is `in_rs` and b is `in_rb`.
- R2: Code 6 shifts `in_rs` left and code 7 shifts it right with zero fill, by the count in `in_rb[5:0]`, when that count is below 32 (0x80 shifted left by 16 gives 0x00800000).
- R3: For codes 6 and 7, a count of 32 to 63 gives 0, and `in_rb[31:6]` has no effect on any shift result.
- R4: Code 8 shifts right while copying the sign bit (0x80000000 by 3 gives 0xF0000000, and 0x8000 by 3 gives 0x1000). A count of 32 to 63 gives 32 copies of bit 31.
- R5: Codes 9 to 15 give a zero result with `out_illegal` high and leave `cr` unchanged. Legal codes give `out_illegal` low.
- R6: With `in_rec` low, `cr` is unchanged by the operation.
- R7: With `in_rec` high, `cr[31:29]` is loaded with {result bit 31 set, result positive and non-zero, result zero}, exactly one of which is set. `cr[28:0]` keeps its value, and the result is the same as without the record flag.
- R8: An accepted request shows its result, `out_illegal` and the updated `cr` with `out_valid` high on the clock edge that follows acceptance.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and `out_illegal` hold steady and no request is accepted.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_result`, `out_illegal` and `cr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 4 | Operation code |
| in_rs | input | 32 | Source operand |
| in_rb | input | 32 | Second operand or shift count |
| in_rec | input | 1 | Record form: update condition field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Operation result |
| out_illegal | output | 1 | Request carried an unused code |
| cr | output | 32 | Condition register |

## Verification
The embedded assertions check the following on every cycle:
- the handshake: one-cycle latency and results held under back-pressure;
- the one-hot form of the condition field after a record-form operation;
- a condition register that stays put without one;
- the zero result of illegal codes;
- the zero and sign-fill results of over-range shift counts.

Only the directed scenarios can show that each operation code computes the right function and that the sign/zero encoding matches the result value. They also show that the upper count bits are ignored and that a request offered during a stall is taken only after the stall ends.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

  typedef enum logic [3:0] {
    OP_OR   = 4'd0,
    OP_ORC  = 4'd1,
    OP_XOR  = 4'd2,
    OP_NAND = 4'd3,
    OP_NOR  = 4'd4,
    OP_EQV  = 4'd5,
    OP_SLW  = 4'd6,
    OP_SRW  = 4'd7,
    OP_SRAW = 4'd8
  } lsx_op_e;

  localparam int unsigned OP_W = 4;

  // Sign/zero summary, packed so that lt lands in the top bit.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } lsx_cond_t;

  localparam int unsigned COND_W = $bits(lsx_cond_t);

endpackage

// File: rtl/lsx_logic.sv
module lsx_logic
  import lsx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              hit
);

  always_comb begin
    hit = 1'b1;
    unique case (op)
      OP_OR:   res = a | b;
      OP_ORC:  res = a | ~b;
      OP_XOR:  res = a ^ b;
      OP_NAND: res = ~(a & b);
      OP_NOR:  res = ~(a | b);
      OP_EQV:  res = ~(a ^ b);
      default: begin
        res = '0;
        hit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lsx_shifter.sv
module lsx_shifter
  import lsx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SH_W   = $clog2(DATA_W) + 1
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] res,
  output logic              hit
);

  localparam int unsigned LOG_W = $clog2(DATA_W);

  logic left, arith, fill, over;
  logic [DATA_W-1:0] a_rev, out_rev;
  logic [DATA_W-1:0] stage [0:LOG_W];

  assign left  = (op == OP_SLW);
  assign arith = (op == OP_SRAW);
  assign hit   = left || arith || (op == OP_SRW);
  assign fill  = arith & a[DATA_W-1];
  // Any count bit at or above log2(width) means the whole word shifts out.
  assign over  = |shamt[SH_W-1:LOG_W];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) a_rev[i] = a[DATA_W-1-i];
  end

  // A left shift runs through the same right-shift network on a reversed word.
  assign stage[0] = left ? a_rev : a;

  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stage[k+1] = shamt[k]
      ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]}
      : stage[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) out_rev[i] = stage[LOG_W][DATA_W-1-i];
  end

  always_comb begin
    if (!hit)       res = '0;
    else if (over)  res = {DATA_W{fill}};
    else if (left)  res = out_rev;
    else            res = stage[LOG_W];
  end

  // R3 / R4: an over-range count leaves only zero or sign fill.
  always_comb begin
    if (hit && over && !arith)
      a_r3_overrange_zero: assert (res == '0);
    if (hit && over && arith)
      a_r4_overrange_fill: assert (res == {DATA_W{a[DATA_W-1]}});
  end

endmodule

// File: rtl/lsx_cond.sv
module lsx_cond
  import lsx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  output lsx_cond_t         cond
);

  always_comb begin
    cond.lt = value[DATA_W-1];
    cond.eq = (value == '0);
    cond.gt = !value[DATA_W-1] && (value != '0);
  end

endmodule

// File: rtl/lsx_exec_unit.sv
module lsx_exec_unit
  import lsx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CR_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [DATA_W-1:0] in_rb,
  input  logic              in_rec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal,
  output logic [CR_W-1:0]   cr
);

  localparam int unsigned SH_W  = $clog2(DATA_W) + 1;
  localparam int unsigned CR_LO = CR_W - COND_W;

  logic [DATA_W-1:0] log_res, sh_res, res_next;
  logic              log_hit, sh_hit, illegal;
  logic              fire;
  lsx_cond_t         cond;

  lsx_logic #(.DATA_W(DATA_W)) u_logic (
    .op (in_op), .a (in_rs), .b (in_rb), .res (log_res), .hit (log_hit)
  );

  lsx_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .op (in_op), .a (in_rs), .shamt (in_rb[SH_W-1:0]),
    .res (sh_res), .hit (sh_hit)
  );

  assign illegal  = !(log_hit || sh_hit);
  assign res_next = log_hit ? log_res : (sh_hit ? sh_res : '0);

  lsx_cond #(.DATA_W(DATA_W)) u_cond (.value (res_next), .cond (cond));

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
      cr          <= '0;
    end else begin
      if (fire) begin
        out_valid   <= 1'b1;
        out_result  <= res_next;
        out_illegal <= illegal;
        if (in_rec && !illegal) cr[CR_W-1:CR_LO] <= cond;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8: acceptance produces a result on the next edge.
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  // R9: a stalled result holds and blocks new requests.
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  // R6: without a record-form acceptance the condition register is stable.
  a_r6_cr_stable: assert property (@(posedge clk) disable iff (rst)
    !(fire && in_rec) |=> $stable(cr));

  // R7: a legal record-form operation leaves exactly one condition bit set.
  a_r7_cond_onehot: assert property (@(posedge clk) disable iff (rst)
    (fire && in_rec && !illegal) |=> ($countones(cr[CR_W-1:CR_LO]) == 1));

  // R7: the low condition bits are never touched.
  a_r7_low_stable: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cr[CR_LO-1:0]));

  // R5: an illegal result is zero.
  a_r5_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == '0));

endmodule

// File: tb/tb_lsx_exec_unit.sv
`timescale 1ns/1ps
module tb_lsx_exec_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_rec, out_valid, out_ready, out_illegal;
  logic [3:0]  in_op;
  logic [31:0] in_rs, in_rb, out_result, cr;
  logic [31:0] cr_exp;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  lsx_exec_unit dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_op (in_op), .in_rs (in_rs), .in_rb (in_rb), .in_rec (in_rec),
    .out_valid (out_valid), .out_ready (out_ready), .out_result (out_result),
    .out_illegal (out_illegal), .cr (cr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    int sh;
    sh = int'(b[5:0]);
    case (op)
      4'd0: return a | b;
      4'd1: return a | ~b;
      4'd2: return a ^ b;
      4'd3: return ~(a & b);
      4'd4: return ~(a | b);
      4'd5: return ~(a ^ b);
      4'd6: return (sh >= 32) ? 32'd0 : (a << sh);
      4'd7: return (sh >= 32) ? 32'd0 : (a >> sh);
      4'd8: return (sh >= 32) ? {32{a[31]}} : 32'($signed(a) >>> sh);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [2:0] cond_of(input logic [31:0] v);
    return {v[31], (!v[31] && v != 0), (v == 0)};
  endfunction

  // One request with the consumer always ready; checks result, flag and cr.
  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic rec, input string tag, input logic [31:0] exp);
    logic [31:0] e;
    @(negedge clk);
    in_valid = 1; in_op = op; in_rs = a; in_rb = b; in_rec = rec; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    e = model(op, a, b);
    if (rec && op <= 4'd8) cr_exp[31:29] = cond_of(e);
    chk(out_valid === 1'b1, {tag, " R8 valid"}, {31'd0, out_valid}, 32'd1);
    chk(out_result === exp, tag, out_result, exp);
    chk(out_illegal === (op > 4'd8), {tag, " R5 flag"}, {31'd0, out_illegal}, {31'd0, op > 4'd8});
    chk(cr === cr_exp, {tag, " cr"}, cr, cr_exp);
  endtask

  task automatic t_reset();
    rst = 1; in_valid = 0; in_op = 0; in_rs = 0; in_rb = 0; in_rec = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    cr_exp = 0;
    chk(out_valid === 0 && out_illegal === 0, "R10 flags", {30'd0, out_valid, out_illegal}, 0);
    chk(out_result === 0 && cr === 0, "R10 data", out_result | cr, 0);
    chk(in_ready === 1, "R9 ready idle", {31'd0, in_ready}, 1);
  endtask

  task automatic t_bitwise();
    run_op(0, 32'h1234, 32'h5678, 0, "R1 or",   32'h0000_567C);
    run_op(1, 32'h1234, 32'h5678, 0, "R1 orc",  32'hFFFF_BBB7);
    run_op(2, 32'h1234, 32'h5678, 0, "R1 xor",  32'h0000_444C);
    run_op(3, 32'h1234, 32'h5678, 0, "R1 nand", 32'hFFFF_EDCF);
    run_op(4, 32'h1234, 32'h5678, 0, "R1 nor",  32'hFFFF_A983);
    run_op(5, 32'h1234, 32'h5678, 0, "R1 eqv",  32'hFFFF_BBB3);
  endtask

  task automatic t_shifts();
    run_op(6, 32'h80, 16, 0, "R2 slw16", 32'h0080_0000);
    run_op(7, 32'h0080_0000, 16, 0, "R2 srw16", 32'h80);
    run_op(6, 32'hA5A5_A5A5, 0, 0, "R2 slw0", 32'hA5A5_A5A5);
    run_op(7, 32'h8000_0001, 31, 0, "R2 srw31", 32'h1);
    run_op(6, 32'h80, 32, 0, "R3 slw32", 32'h0);
    run_op(7, 32'h0080_0000, 32, 0, "R3 srw32", 32'h0);
    run_op(6, 32'hFFFF_FFFF, 63, 0, "R3 slw63", 32'h0);
    run_op(6, 32'h80, 32'hFFFF_FF90, 0, "R3 slw high bits", 32'h0080_0000);
    run_op(7, 32'hF000_0000, 32'h1234_5044, 0, "R3 srw high bits", 32'h0F00_0000);
    run_op(8, 32'h8000_0000, 3, 0, "R4 sraw neg", 32'hF000_0000);
    run_op(8, 32'h8000, 3, 0, "R4 sraw pos", 32'h1000);
    run_op(8, 32'h8000_1234, 40, 0, "R4 sraw over neg", 32'hFFFF_FFFF);
    run_op(8, 32'h7FFF_FFFF, 32, 0, "R4 sraw over pos", 32'h0);
  endtask

  task automatic t_record();
    run_op(2, 32'h1234, 32'h1234, 1, "R7 zero", 32'h0);
    chk(cr[31:29] === 3'b001, "R7 eq bit", {29'd0, cr[31:29]}, 1);
    run_op(0, 32'h8000_0000, 32'h1, 1, "R7 neg", 32'h8000_0001);
    chk(cr[31:29] === 3'b100, "R7 lt bit", {29'd0, cr[31:29]}, 4);
    run_op(6, 32'h80, 16, 1, "R7 pos", 32'h0080_0000);
    chk(cr[31:29] === 3'b010, "R7 gt bit", {29'd0, cr[31:29]}, 2);
    run_op(4, 32'h0, 32'h0, 0, "R6 no record", 32'hFFFF_FFFF);
    chk(cr[31:29] === 3'b010, "R6 cr kept", {29'd0, cr[31:29]}, 2);
  endtask

  task automatic t_illegal();
    for (int c = 9; c < 16; c++) run_op(4'(c), 32'hDEAD_BEEF, 32'h5, 1, "R5 illegal", 32'h0);
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'hACE1_2345;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = lf; lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b = lf; lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run_op(4'(i % 9), a, b, i[0], "R1 R2 R4 R7 sweep", model(4'(i % 9), a, b));
    end
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_op = 2; in_rs = 32'hF0F0; in_rb = 32'h0FF0; in_rec = 0;
    @(negedge clk);
    in_op = 4; in_rs = 0; in_rb = 0;
    held = out_result;
    chk(out_valid === 1 && held === 32'hFF00, "R8 stalled first", held, 32'hFF00);
    chk(in_ready === 0, "R9 ready low", {31'd0, in_ready}, 0);
    repeat (3) @(negedge clk);
    chk(out_result === held && out_valid === 1, "R9 held", out_result, held);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid === 1 && out_result === 32'hFFFF_FFFF, "R9 pending taken", out_result, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(out_valid === 0, "R9 drained", {31'd0, out_valid}, 0);
  endtask

  initial begin
    t_reset();
    t_bitwise();
    t_shifts();
    t_record();
    t_illegal();
    t_sweep();
    t_backpressure();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(cr === 0 && out_valid === 0, "R10 reset again", cr, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule